// File: doc/BRIEF.md
# Line-Rate Divider with Programmable Active Window

This block divides the dot clock by a programmable even ratio N to form one display line. A free-running count steps from zero up to the programmed value N-1 and then returns to zero. While the count is in the lower half of its period, a square phase pulse is high. An external phase-locked loop compares this pulse with HSYNC to regenerate the dot clock. When that loop is not in use, a strap input allows the active HSYNC edge to restart the count directly instead. A polarity bit states which edge of the HSYNC pin is the active one.

Two programmed 11-bit positions decode an active window from the count. Bit 0 of each position is ignored, so the window moves in 2-dot steps. When the window falls, an auxiliary active-low horizontal pulse of fixed width follows after a fixed delay. At the start of each such pulse, the block latches the VSYNC level. It then presents that level as an auxiliary vertical pulse that is active-low, whatever the input polarity.

The block has two state machines. The window machine has the states `WIN_HI` (window high) and `WIN_LO` (window low). It takes `WIN_HI -> WIN_LO` on a fall match and `WIN_LO -> WIN_HI` on a rise match. It is forced to `WIN_HI` whenever the two positions are equal. The auxiliary machine has the states `AUX_IDLE`, `AUX_WAIT` and `AUX_LOW`. It takes `AUX_IDLE -> AUX_WAIT` on a window fall. It takes `AUX_WAIT -> AUX_LOW` once the delay has elapsed, and `AUX_LOW -> AUX_IDLE` once the pulse width has elapsed.

Top module: `line_timing_gen`

## Requirements
- R1: With no restart, the count steps by one on each clock and returns to 0 on the clock after it reaches `ratio_m1`. One line is therefore `ratio_m1`+1 clocks. `ratio_m1` is odd, so N is even and at most 2048.
- R2: `phase_out` is high exactly while the count is at most `ratio_m1`>>1, which is the first N/2 counts of each period. It follows the count in the same cycle.
- R3: When `hreset_dis` is 0, an active HSYNC edge restarts the count. Suppose the pin first shows its active level at clock edge k, after being inactive at edge k-1. Then the count is 0 after edge k+1.
- R4: When `hreset_dis` is 1, HSYNC has no effect on the count or on any output.
- R5: When `hsync_pol` is 1, the active HSYNC level is high, and when it is 0 the active level is low. The restart edge of R3 is the inactive-to-active transition.
- R6: `win_out` goes low on the clock after the count first satisfies count[10:1] == `win_fall`[10:1]. It goes high on the clock after the count first satisfies count[10:1] == `win_rise`[10:1]. Bit 0 of both positions is ignored.
- R7: When `win_fall`[10:1] == `win_rise`[10:1], `win_out` is high from the next clock on.
- R8: `aux_h_n` goes low 34 clocks after the clock at which `win_out` falls and stays low for exactly 32 clocks. A window fall during the delay or during the pulse starts no new pulse.
- R9: At the clock at which `aux_h_n` goes low, `aux_v_n` takes the value 0 if VSYNC is at its active level and 1 otherwise. The active level is high when `vsync_pol` is 1 and low when it is 0. `aux_v_n` changes at no other time.
- R10: During and just after reset, the count is 0, `phase_out` is high, and `win_out`, `aux_h_n` and `aux_v_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync pin |
| vsync_in | input | 1 | Vertical sync pin |
| hsync_pol | input | 1 | HSYNC active level (1 high, 0 low) |
| vsync_pol | input | 1 | VSYNC active level (1 high, 0 low) |
| hreset_dis | input | 1 | 1: HSYNC never restarts the count |
| ratio_m1 | input | 11 | Clocks per line minus one (odd) |
| win_fall | input | 11 | Window fall position, bit 0 ignored |
| win_rise | input | 11 | Window rise position, bit 0 ignored |
| phase_out | output | 1 | 50 % phase-comparison pulse |
| win_out | output | 1 | Active window, low between fall and rise |
| aux_h_n | output | 1 | Delayed 32-clock active-low line pulse |
| aux_v_n | output | 1 | VSYNC latched at aux pulse start, active-low |

## Verification
The results are due at different latencies:
- `phase_out` is due in the same cycle as the count that produces it.
- A restart shows as count 0 two edges after HSYNC first reads active.
- `win_out` responds one edge after the matching count.
- `aux_h_n` and `aux_v_n` move 34 edges after the window fall, and `aux_h_n` recovers 32 edges later.

The reference model advances its own count, window and pulse-age integers on every rising edge from the inputs held at that edge. It compares all four outputs 1 ns later, so each expected value already includes every register on the way.

// File: rtl/line_timing_pkg.sv
`timescale 1ns/1ps
package line_timing_pkg;

    localparam int unsigned LT_CW       = 11;
    localparam int unsigned LT_AUX_DLY  = 34;
    localparam int unsigned LT_AUX_WID  = 32;

    typedef enum logic {
        WIN_HI = 1'b0,
        WIN_LO = 1'b1
    } win_state_e;

    typedef enum logic [1:0] {
        AUX_IDLE = 2'd0,
        AUX_WAIT = 2'd1,
        AUX_LOW  = 2'd2
    } aux_state_e;

endpackage

// File: rtl/line_div_counter.sv
`timescale 1ns/1ps
module line_div_counter #(
    parameter int unsigned CW = line_timing_pkg::LT_CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hsync_in,
    input  logic          hsync_pol,
    input  logic          hreset_dis,
    input  logic [CW-1:0] ratio_m1,
    output logic [CW-1:0] cnt,
    output logic          restart,
    output logic          phase_out
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic          hs_now_q;
    logic          hs_old_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] half_lim;

    // Normalise the pin so that 1 always means "active".
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_now_q <= 1'b0;
            hs_old_q <= 1'b0;
        end else begin
            hs_now_q <= (hsync_in == hsync_pol);
            hs_old_q <= hs_now_q;
        end
    end

    assign restart = hs_now_q && !hs_old_q && !hreset_dis;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (cnt_q >= ratio_m1) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign half_lim  = {1'b0, ratio_m1[CW-1:1]};
    assign phase_out = (cnt_q <= half_lim);
    assign cnt       = cnt_q;

endmodule

// File: rtl/line_window_fsm.sv
`timescale 1ns/1ps
module line_window_fsm
    import line_timing_pkg::*;
#(
    parameter int unsigned CW = LT_CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] win_fall,
    input  logic [CW-1:0] win_rise,
    output logic          win_out,
    output logic          fall_go
);

    win_state_e state_q;
    win_state_e state_d;
    logic       hit_fall;
    logic       hit_rise;
    logic       pos_equal;

    assign hit_fall  = (cnt[CW-1:1] == win_fall[CW-1:1]);
    assign hit_rise  = (cnt[CW-1:1] == win_rise[CW-1:1]);
    assign pos_equal = (win_fall[CW-1:1] == win_rise[CW-1:1]);

    always_comb begin
        state_d = state_q;
        if (pos_equal) begin
            state_d = WIN_HI;
        end else begin
            unique case (state_q)
                WIN_HI: if (hit_fall) state_d = WIN_LO;
                WIN_LO: if (hit_rise) state_d = WIN_HI;
                default: state_d = WIN_HI;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WIN_HI;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        win_out = (state_q == WIN_HI);
        fall_go = (state_q == WIN_HI) && (state_d == WIN_LO);
    end

endmodule

// File: rtl/line_aux_fsm.sv
`timescale 1ns/1ps
module line_aux_fsm
    import line_timing_pkg::*;
#(
    parameter int unsigned DLY = LT_AUX_DLY,
    parameter int unsigned WID = LT_AUX_WID
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fall_go,
    input  logic vsync_in,
    input  logic vsync_pol,
    output logic aux_h_n,
    output logic aux_v_n
);

    localparam int unsigned MAXC = (DLY > WID) ? DLY : WID;
    localparam int unsigned TW   = $clog2(MAXC + 1);
    localparam logic [TW-1:0] DLY_LAST = TW'(DLY - 1);
    localparam logic [TW-1:0] WID_LAST = TW'(WID - 1);
    localparam logic [TW-1:0] ONE      = TW'(1);

    aux_state_e     state_q;
    aux_state_e     state_d;
    logic [TW-1:0]  tick_q;
    logic           av_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AUX_IDLE: if (fall_go)            state_d = AUX_WAIT;
            AUX_WAIT: if (tick_q == DLY_LAST) state_d = AUX_LOW;
            AUX_LOW:  if (tick_q == WID_LAST) state_d = AUX_IDLE;
            default:                          state_d = AUX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= AUX_IDLE;
            tick_q  <= '0;
            av_q    <= 1'b1;
        end else begin
            state_q <= state_d;
            if (state_d != state_q || state_d == AUX_IDLE) begin
                tick_q <= '0;
            end else begin
                tick_q <= tick_q + ONE;
            end
            if (state_q == AUX_WAIT && state_d == AUX_LOW) begin
                av_q <= !(vsync_in == vsync_pol);
            end
        end
    end

    always_comb begin
        aux_h_n = (state_q != AUX_LOW);
        aux_v_n = av_q;
    end

endmodule

// File: rtl/line_timing_gen.sv
`timescale 1ns/1ps
module line_timing_gen
    import line_timing_pkg::*;
#(
    parameter int unsigned CW      = LT_CW,
    parameter int unsigned AUX_DLY = LT_AUX_DLY,
    parameter int unsigned AUX_WID = LT_AUX_WID
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hsync_in,
    input  logic          vsync_in,
    input  logic          hsync_pol,
    input  logic          vsync_pol,
    input  logic          hreset_dis,
    input  logic [CW-1:0] ratio_m1,
    input  logic [CW-1:0] win_fall,
    input  logic [CW-1:0] win_rise,
    output logic          phase_out,
    output logic          win_out,
    output logic          aux_h_n,
    output logic          aux_v_n
);

    logic [CW-1:0] cnt_w;
    logic          restart_w;
    logic          fall_go_w;

    line_div_counter #(.CW(CW)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .hsync_in   (hsync_in),
        .hsync_pol  (hsync_pol),
        .hreset_dis (hreset_dis),
        .ratio_m1   (ratio_m1),
        .cnt        (cnt_w),
        .restart    (restart_w),
        .phase_out  (phase_out)
    );

    line_window_fsm #(.CW(CW)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt      (cnt_w),
        .win_fall (win_fall),
        .win_rise (win_rise),
        .win_out  (win_out),
        .fall_go  (fall_go_w)
    );

    line_aux_fsm #(.DLY(AUX_DLY), .WID(AUX_WID)) u_aux (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_go   (fall_go_w),
        .vsync_in  (vsync_in),
        .vsync_pol (vsync_pol),
        .aux_h_n   (aux_h_n),
        .aux_v_n   (aux_v_n)
    );

endmodule

// File: rtl/line_timing_chk.sv
`timescale 1ns/1ps
module line_timing_chk #(
    parameter int unsigned CW  = 11,
    parameter int unsigned WID = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] ratio_m1,
    input logic [CW-1:0] win_fall,
    input logic [CW-1:0] win_rise,
    input logic [CW-1:0] cnt,
    input logic          restart,
    input logic          win_out,
    input logic          aux_h_n,
    input logic          aux_v_n
);

    logic [7:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (aux_h_n) begin
            low_run <= '0;
        end else begin
            low_run <= low_run + 8'd1;
        end
    end

    // R1: an uninterrupted count below the limit advances by one
    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && cnt < ratio_m1) |=> (cnt == $past(cnt) + CW'(1)));

    // R3: a recognised sync edge returns the count to zero
    p_sync_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));

    // R7: equal positions keep the window high
    p_equal_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (win_fall[CW-1:1] == win_rise[CW-1:1]) |=> win_out);

    // R8: every auxiliary pulse is exactly the programmed width
    p_aux_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aux_h_n) |-> (low_run == 8'(WID)));

    // R9: the latched vertical level only moves when the pulse starts
    p_vlatch_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(aux_h_n) |-> $stable(aux_v_n));

endmodule

bind line_timing_gen line_timing_chk #(.CW(CW), .WID(AUX_WID)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ratio_m1 (ratio_m1),
    .win_fall (win_fall),
    .win_rise (win_rise),
    .cnt      (cnt_w),
    .restart  (restart_w),
    .win_out  (win_out),
    .aux_h_n  (aux_h_n),
    .aux_v_n  (aux_v_n)
);

// File: tb/line_timing_gen_tb_top.sv
`timescale 1ns/1ps
module line_timing_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsync_in = 1'b1;
    logic        vsync_in = 1'b1;
    logic        hsync_pol = 1'b0;
    logic        vsync_pol = 1'b0;
    logic        hreset_dis = 1'b1;
    logic [10:0] ratio_m1 = 11'h53F;
    logic [10:0] win_fall = 11'h000;
    logic [10:0] win_rise = 11'h080;
    logic        phase_out, win_out, aux_h_n, aux_v_n;

    int errors = 0;
    int checks = 0;
    string tag = "R10";

    // reference model state
    int m_cnt = 0;
    int m_age = -1;
    bit m_h1 = 0, m_h2 = 0, m_win = 1, m_av = 1;
    bit started = 0;

    always #2 clk = ~clk;

    line_timing_gen dut_i (
        .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .hsync_pol(hsync_pol), .vsync_pol(vsync_pol), .hreset_dis(hreset_dis),
        .ratio_m1(ratio_m1), .win_fall(win_fall), .win_rise(win_rise),
        .phase_out(phase_out), .win_out(win_out), .aux_h_n(aux_h_n), .aux_v_n(aux_v_n)
    );

    task automatic check(input string what, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s t=%0t actual=%b expected=%b", tag, what, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        bit hn, rs, nw, fe, eqw;
        int nc;
        if (!rst_n) begin
            m_cnt = 0; m_h1 = 0; m_h2 = 0; m_win = 1; m_age = -1; m_av = 1;
        end else begin
            hn  = (hsync_in == hsync_pol);
            rs  = m_h1 && !m_h2 && !hreset_dis;
            nc  = rs ? 0 : ((m_cnt >= int'(ratio_m1)) ? 0 : m_cnt + 1);
            eqw = (int'(win_fall) / 2) == (int'(win_rise) / 2);
            if (eqw)        nw = 1;
            else if (m_win) nw = !((m_cnt / 2) == (int'(win_fall) / 2));
            else            nw = ((m_cnt / 2) == (int'(win_rise) / 2));
            fe = m_win && !nw;
            if (m_age >= 0) begin
                m_age++;
                if (m_age == 34) m_av = !(vsync_in == vsync_pol);
                if (m_age == 66) m_age = -1;
            end else if (fe) begin
                m_age = 0;
            end
            m_h2 = m_h1; m_h1 = hn; m_cnt = nc; m_win = nw;
        end
        started = 1;
        #1;
        check("R2 phase_out", phase_out, m_cnt <= (int'(ratio_m1) / 2));
        check("R6 win_out", win_out, m_win);
        check("R8 aux_h_n", aux_h_n, !(m_age >= 34 && m_age <= 65));
        check("R9 aux_v_n", aux_v_n, m_av);
    end

    task automatic hs_pulse(input int gap, input int width);
        repeat (gap) @(negedge clk);
        hsync_in = hsync_pol;
        repeat (width) @(negedge clk);
        hsync_in = !hsync_pol;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if ((i % 611) == 300) vsync_in = !vsync_in;
        end
    endtask

    initial begin
        tag = "R10 reset";
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        tag = "R1 R2 R6 R8 R9 default line";
        run(4200);

        tag = "R1 R6 short line odd positions";
        ratio_m1 = 11'h0FF; win_fall = 11'h021; win_rise = 11'h061;
        run(1600);

        tag = "R8 busy pulse ignores falls";
        ratio_m1 = 11'h03F; win_fall = 11'h002; win_rise = 11'h010;
        run(700);

        tag = "R3 R5 low-active restart";
        ratio_m1 = 11'h1FF; win_fall = 11'h010; win_rise = 11'h090;
        hsync_pol = 1'b0; hsync_in = 1'b1; hreset_dis = 1'b0;
        for (int k = 0; k < 8; k++) hs_pulse(150 + 37 * k, 3 + k);

        tag = "R3 R5 high-active restart";
        hsync_pol = 1'b1; hsync_in = 1'b0;
        for (int k = 0; k < 8; k++) hs_pulse(200 + 23 * k, 2 + k);

        tag = "R4 restart disabled";
        hreset_dis = 1'b1;
        for (int k = 0; k < 8; k++) hs_pulse(170 + 41 * k, 4);

        tag = "R7 equal positions";
        win_fall = 11'h040; win_rise = 11'h041;
        run(1200);
        win_rise = 11'h0A0;
        run(600);

        tag = "R9 high-active vsync";
        vsync_pol = 1'b1;
        run(2500);

        tag = "R10 reset again";
        rst_n = 1'b0;
        run(3);
        rst_n = 1'b1;
        run(300);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL R1 watchdog actual=%0t expected=completion", $time);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule